// File: doc/BRIEF.md
# Staged Deep Idle Entry Controller

This block sits, one per core, between the idle-state request issued by software and the core state that is actually applied. A request for a long-exit-latency idle state is not granted straight away. The core is first parked in the light, fast-wake state, and a countdown is started. The deep state is committed only if the countdown expires with no wake event and no newer request. Short idle periods therefore always wake from the light state, and longer ones still reach the deep state.

Requests for the running or light state are applied on the next clock edge. A wake event always returns the core to the running state. When the applied state moves from light to the deep target, a single-cycle commit pulse marks the change. Power gating, context save and voltage control lie outside this block.

Top module: `staged_idle_ctrl`

## Requirements
- R1: While rst_ni is low, and after it is released, applied_state_o is 0 and commit_o is 0 until a request or wake changes them.
- R2: A request (req_valid_i high, wake_i low) with code 0 sets applied_state_o to 0 at the next rising edge and cancels any pending countdown.
- R3: A request with code 1 sets applied_state_o to 1 at the next edge and cancels any pending countdown.
- R4: Request codes 2, 4, 5 and 7 behave exactly like code 1.
- R5: A request with code 3 or 6 sets applied_state_o to 1 at the next edge, not to the requested code.
- R6: After a code 3 or 6 request with delay value D, applied_state_o stays 1 for D+1 cycles and then becomes the requested code, provided no wake or new request intervenes. D = 0 commits on the edge after the light state is entered.
- R7: commit_o is high for exactly one cycle, in the cycle when applied_state_o first shows the deep code, and only when the previous applied state was 1.
- R8: A wake during the countdown sets applied_state_o to 0 at the next edge, and the deep code is never applied for that request.
- R9: A wake sets applied_state_o to 0 at the next edge from any state, and it takes priority over a request in the same cycle.
- R10: A request that arrives during a countdown replaces the target and restarts the countdown with the delay value present at that time.
- R11: delay_i is sampled only with a deep request. Changes to it during a countdown do not alter the commit cycle.
- R12: applied_state_o only ever takes the values 0, 1, 3 or 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe, one cycle per request |
| req_state_i | input | 3 | Requested core state code |
| wake_i | input | 1 | Wake / break event |
| delay_i | input | DLY_W | Light-state dwell in cycles before a deep commit |
| applied_state_o | output | 3 | Core state currently applied |
| commit_o | output | 1 | One-cycle pulse on the light-to-deep transition |

## Verification
The assertions assume that req_state_i is only meaningful in cycles where req_valid_i is high. They also assume that wake_i and req_valid_i may be high together, with the wake taking precedence. delay_i is assumed to matter only in the cycle of a deep request. The stimulus drives every input on the falling edge with known values, and it deliberately changes delay_i in the middle of a countdown. It also issues requests on top of pending countdowns and raises wake together with a request, so that each of these assumptions is exercised at its edge rather than avoided.

// File: rtl/staged_idle_pkg.sv
package staged_idle_pkg;
  typedef logic [2:0] cstate_t;

  localparam cstate_t CS_RUN   = 3'd0;
  localparam cstate_t CS_LIGHT = 3'd1;
  localparam cstate_t CS_RET   = 3'd3;
  localparam cstate_t CS_OFF   = 3'd6;

  typedef enum logic [1:0] {
    RQ_RUN,
    RQ_LIGHT,
    RQ_DEEP
  } rq_kind_t;

  typedef enum logic [1:0] {
    PH_RUN,
    PH_LIGHT,
    PH_WAIT,
    PH_DEEP
  } phase_t;
endpackage

// File: rtl/idle_req_decode.sv
module idle_req_decode
  import staged_idle_pkg::*;
(
  input  logic [2:0] code_i,
  output rq_kind_t   kind_o,
  output cstate_t    target_o
);
  always_comb begin
    kind_o   = RQ_LIGHT;
    target_o = CS_LIGHT;
    unique case (code_i)
      CS_RUN: begin
        kind_o   = RQ_RUN;
        target_o = CS_RUN;
      end
      CS_RET, CS_OFF: begin
        kind_o   = RQ_DEEP;
        target_o = code_i;
      end
      default: begin
        // unsupported codes fold onto the light state
        kind_o   = RQ_LIGHT;
        target_o = CS_LIGHT;
      end
    endcase
  end
endmodule

// File: rtl/idle_delay_timer.sv
module idle_delay_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         clear_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;
  logic         armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (clear_i) begin
      armed_q <= 1'b0;
    end else if (load_i) begin
      cnt_q   <= load_val_i;
      armed_q <= 1'b1;
    end else if (armed_q && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = armed_q && (cnt_q == '0);
endmodule

// File: rtl/idle_stage_fsm.sv
module idle_stage_fsm
  import staged_idle_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wake_i,
  input  logic     req_valid_i,
  input  rq_kind_t kind_i,
  input  cstate_t  target_i,
  input  logic     expired_i,
  output logic     load_o,
  output logic     clear_o,
  output cstate_t  applied_o,
  output logic     commit_o
);
  phase_t  phase_q, phase_d;
  cstate_t applied_q, applied_d;
  cstate_t target_q, target_d;
  logic    commit_q, commit_d;

  always_comb begin
    phase_d   = phase_q;
    applied_d = applied_q;
    target_d  = target_q;
    commit_d  = 1'b0;
    load_o    = 1'b0;
    clear_o   = 1'b0;
    if (wake_i) begin
      phase_d   = PH_RUN;
      applied_d = CS_RUN;
      clear_o   = 1'b1;
    end else if (req_valid_i) begin
      unique case (kind_i)
        RQ_RUN: begin
          phase_d   = PH_RUN;
          applied_d = CS_RUN;
          clear_o   = 1'b1;
        end
        RQ_DEEP: begin
          phase_d   = PH_WAIT;
          applied_d = CS_LIGHT;
          target_d  = target_i;
          load_o    = 1'b1;
        end
        default: begin
          phase_d   = PH_LIGHT;
          applied_d = CS_LIGHT;
          clear_o   = 1'b1;
        end
      endcase
    end else if (phase_q == PH_WAIT && expired_i) begin
      phase_d   = PH_DEEP;
      applied_d = target_q;
      commit_d  = 1'b1;
      clear_o   = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_RUN;
      applied_q <= CS_RUN;
      target_q  <= CS_LIGHT;
      commit_q  <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      applied_q <= applied_d;
      target_q  <= target_d;
      commit_q  <= commit_d;
    end
  end

  assign applied_o = applied_q;
  assign commit_o  = commit_q;
endmodule

// File: rtl/staged_idle_ctrl.sv
module staged_idle_ctrl
  import staged_idle_pkg::*;
#(
  parameter int unsigned DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [2:0]       req_state_i,
  input  logic             wake_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic [2:0]       applied_state_o,
  output logic             commit_o
);
  rq_kind_t kind;
  cstate_t  target;
  logic     t_load, t_clear, t_expired;

  idle_req_decode u_decode (
    .code_i   (req_state_i),
    .kind_o   (kind),
    .target_o (target)
  );

  idle_delay_timer #(.W(DLY_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (t_load),
    .load_val_i (delay_i),
    .clear_i    (t_clear),
    .expired_o  (t_expired)
  );

  idle_stage_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wake_i      (wake_i),
    .req_valid_i (req_valid_i),
    .kind_i      (kind),
    .target_i    (target),
    .expired_i   (t_expired),
    .load_o      (t_load),
    .clear_o     (t_clear),
    .applied_o   (applied_state_o),
    .commit_o    (commit_o)
  );
endmodule

// File: rtl/staged_idle_ctrl_chk.sv
module staged_idle_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic [2:0] req_state_i,
  input logic       wake_i,
  input logic [2:0] applied_state_o,
  input logic       commit_o
);
  logic app_deep, req_deep, req_run;
  assign app_deep = (applied_state_o == 3'd3) || (applied_state_o == 3'd6);
  assign req_deep = (req_state_i == 3'd3) || (req_state_i == 3'd6);
  assign req_run  = (req_state_i == 3'd0);

  assert_legal_code_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    app_deep || applied_state_o == 3'd0 || applied_state_o == 3'd1);

  assert_commit_from_light_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> app_deep && $past(applied_state_o) == 3'd1);

  assert_commit_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o);

  assert_deep_only_by_commit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (app_deep && applied_state_o != $past(applied_state_o)) |-> commit_o);

  assert_wake_to_run_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |=> applied_state_o == 3'd0);

  assert_run_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !wake_i && req_run) |=> applied_state_o == 3'd0);

  assert_deep_req_parks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !wake_i && req_deep) |=> applied_state_o == 3'd1 && !commit_o);

  assert_other_req_light_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !wake_i && !req_deep && !req_run) |=> applied_state_o == 3'd1);
endmodule

bind staged_idle_ctrl staged_idle_ctrl_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .req_state_i     (req_state_i),
  .wake_i          (wake_i),
  .applied_state_o (applied_state_o),
  .commit_o        (commit_o)
);

// File: tb/staged_idle_ctrl_bench.sv
module staged_idle_ctrl_bench;
  localparam int DW = 8;
  localparam int NV = 32;

  typedef struct packed {
    logic          v;
    logic [2:0]    code;
    logic          wake;
    logic [DW-1:0] dly;
    logic [2:0]    app;
    logic          cm;
    logic [3:0]    rq;
  } vec_t;

  // inputs for one edge, expected outputs after it
  localparam vec_t VEC [NV] = '{
    '{1'b0, 3'd0, 1'b0, 8'd0, 3'd0, 1'b0, 4'd1 },  // 0  R1 idle
    '{1'b1, 3'd1, 1'b0, 8'd0, 3'd1, 1'b0, 4'd3 },  // 1  R3
    '{1'b1, 3'd0, 1'b0, 8'd0, 3'd0, 1'b0, 4'd2 },  // 2  R2
    '{1'b1, 3'd5, 1'b0, 8'd0, 3'd1, 1'b0, 4'd4 },  // 3  R4
    '{1'b1, 3'd3, 1'b0, 8'd2, 3'd1, 1'b0, 4'd5 },  // 4  R5 cnt=2
    '{1'b0, 3'd0, 1'b0, 8'd0, 3'd1, 1'b0, 4'd6 },  // 5  R6
    '{1'b0, 3'd0, 1'b0, 8'd7, 3'd1, 1'b0, 4'd11},  // 6  R11 delay change ignored
    '{1'b0, 3'd0, 1'b0, 8'd7, 3'd3, 1'b1, 4'd7 },  // 7  R7 commit
    '{1'b0, 3'd0, 1'b0, 8'd0, 3'd3, 1'b0, 4'd7 },  // 8  R7 single pulse
    '{1'b0, 3'd0, 1'b1, 8'd0, 3'd0, 1'b0, 4'd9 },  // 9  R9 wake from deep
    '{1'b1, 3'd6, 1'b0, 8'd0, 3'd1, 1'b0, 4'd5 },  // 10 R5
    '{1'b0, 3'd0, 1'b0, 8'd0, 3'd6, 1'b1, 4'd6 },  // 11 R6 zero delay
    '{1'b1, 3'd6, 1'b0, 8'd3, 3'd1, 1'b0, 4'd5 },  // 12 R5 from deep
    '{1'b0, 3'd0, 1'b1, 8'd0, 3'd0, 1'b0, 4'd8 },  // 13 R8 wake in countdown
    '{1'b0, 3'd0, 1'b0, 8'd0, 3'd0, 1'b0, 4'd8 },  // 14 R8
    '{1'b0, 3'd0, 1'b0, 8'd0, 3'd0, 1'b0, 4'd8 },  // 15 R8
    '{1'b0, 3'd0, 1'b0, 8'd0, 3'd0, 1'b0, 4'd8 },  // 16 R8
    '{1'b1, 3'd3, 1'b0, 8'd3, 3'd1, 1'b0, 4'd5 },  // 17 R5 cnt=3
    '{1'b0, 3'd0, 1'b0, 8'd0, 3'd1, 1'b0, 4'd6 },  // 18 R6
    '{1'b1, 3'd6, 1'b0, 8'd1, 3'd1, 1'b0, 4'd10},  // 19 R10 restart
    '{1'b0, 3'd0, 1'b0, 8'd0, 3'd1, 1'b0, 4'd10},  // 20 R10
    '{1'b0, 3'd0, 1'b0, 8'd0, 3'd6, 1'b1, 4'd10},  // 21 R10 new target
    '{1'b1, 3'd3, 1'b1, 8'd0, 3'd0, 1'b0, 4'd9 },  // 22 R9 wake wins
    '{1'b0, 3'd0, 1'b0, 8'd0, 3'd0, 1'b0, 4'd9 },  // 23 R9
    '{1'b1, 3'd7, 1'b0, 8'd0, 3'd1, 1'b0, 4'd4 },  // 24 R4
    '{1'b0, 3'd0, 1'b0, 8'd0, 3'd1, 1'b0, 4'd4 },  // 25 R4 no commit
    '{1'b1, 3'd2, 1'b0, 8'd0, 3'd1, 1'b0, 4'd4 },  // 26 R4
    '{1'b1, 3'd3, 1'b0, 8'd1, 3'd1, 1'b0, 4'd5 },  // 27 R5 cnt=1
    '{1'b1, 3'd1, 1'b0, 8'd0, 3'd1, 1'b0, 4'd3 },  // 28 R3 cancels
    '{1'b0, 3'd0, 1'b0, 8'd0, 3'd1, 1'b0, 4'd3 },  // 29 R3
    '{1'b0, 3'd0, 1'b0, 8'd0, 3'd1, 1'b0, 4'd3 },  // 30 R3
    '{1'b1, 3'd4, 1'b0, 8'd0, 3'd1, 1'b0, 4'd4 }   // 31 R4
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic [2:0]    req_state_i = '0;
  logic          wake_i = 1'b0;
  logic [DW-1:0] delay_i = '0;
  logic [2:0]    applied_state_o;
  logic          commit_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  staged_idle_ctrl #(.DLY_W(DW)) u_staged_idle_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_valid_i     (req_valid_i),
    .req_state_i     (req_state_i),
    .wake_i          (wake_i),
    .delay_i         (delay_i),
    .applied_state_o (applied_state_o),
    .commit_o        (commit_o)
  );

  task automatic check(input int rq, input logic [2:0] e_app, input logic e_cm, input string what);
    n_chk++;
    if (applied_state_o !== e_app || commit_o !== e_cm) begin
      n_bad++;
      $display("FAIL R%0d %s: applied=%0d commit=%0b expected applied=%0d commit=%0b",
               rq, what, applied_state_o, commit_o, e_app, e_cm);
    end
  endtask

  task automatic drive(input logic v, input logic [2:0] c, input logic w, input logic [DW-1:0] d);
    req_valid_i = v;
    req_state_i = c;
    wake_i      = w;
    delay_i     = d;
  endtask

  task automatic step;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk_i);
    check(1, 3'd0, 1'b0, "in reset");
    rst_ni = 1'b1;
    step();
    check(1, 3'd0, 1'b0, "after release");

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].v, VEC[i].code, VEC[i].wake, VEC[i].dly);
      step();
      check(int'(VEC[i].rq), VEC[i].app, VEC[i].cm, $sformatf("vector %0d", i));
    end
    drive(1'b0, 3'd0, 1'b1, '0);
    step();
    drive(1'b0, 3'd0, 1'b0, '0);

    // R6 long dwell: D=20 gives 21 light cycles then commit
    drive(1'b1, 3'd3, 1'b0, 8'd20);
    step();
    drive(1'b0, 3'd0, 1'b0, 8'd0);
    check(6, 3'd1, 1'b0, "long dwell entry");
    for (int k = 0; k < 20; k++) begin
      step();
      check(6, 3'd1, 1'b0, $sformatf("long dwell cycle %0d", k));
    end
    step();
    check(6, 3'd3, 1'b1, "long dwell commit");
    step();
    check(7, 3'd3, 1'b0, "pulse ends");

    // R1 reset during countdown drops everything
    drive(1'b1, 3'd6, 1'b0, 8'd5);
    step();
    drive(1'b0, 3'd0, 1'b0, 8'd0);
    step();
    rst_ni = 1'b0;
    #1;
    check(1, 3'd0, 1'b0, "async reset mid countdown");
    step();
    rst_ni = 1'b1;
    for (int k = 0; k < 10; k++) begin
      step();
      check(1, 3'd0, 1'b0, $sformatf("no commit after reset %0d", k));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog: applied=%0d commit=%0b expected completion",
               applied_state_o, commit_o);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule